// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects six interrupt request sources and presents one request at a time to a processor core. The sources are two external request pins, two timer overflow pulses, a serial port whose receive and transmit flags share one request, and an extra timer. Each request is held in a pending flag. Each source has its own enable bit, and a global enable bit sits above them all. A priority register gives each source one of two levels. When several eligible requests are pending at the same level, a fixed order decides between them.

A two-state machine offers the winning request, together with its handler address, to the core. The two states are `ST_IDLE` (nothing offered) and `ST_OFFER` (`irq_req` high, vector stable). The transition `ST_IDLE -> ST_OFFER` ("take") happens when any eligible request exists. The transition `ST_OFFER -> ST_IDLE` happens in one of two ways. "Service" occurs on `irq_ack`: the in-service bit of the offered level is set and the source's flag is cleared when its kind allows it. "Withdraw" occurs when the offered source is no longer the winner or is no longer eligible, for example because a level pin was released or an enable was cleared. The core pulses `irq_reti` when a handler finishes. This clears the in-service bit of the highest level that is active, which allows a high-level handler to nest inside a low-level one.

The external pins are active low, and each one has a mode input. In edge mode a falling edge latches the flag. In level mode the flag follows the pin.

Top module: `intc_two_level`

## Requirements
- R1: After reset, `enable_q` and `prio_q` read 0x00, `pend_flags` reads 0, `irq_req` is low, and no level is in service.
- R2: Enable bit positions are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 extra timer, 7 global. Bit 6 always reads 0. A pending source is offered only when its own bit and the global bit are both 1.
- R3: While the global enable bit is 0, `irq_req` stays low. Pending flags stay set and are offered once the global enable bit is set.
- R4: Priority bits use the same source positions as R2, and a 1 selects the high level. Bits 7:6 always read 0. An eligible high-level request wins over every low-level request.
- R5: Within one level the order, highest first, is: external 0, timer 0, external 1, timer 1, serial, extra timer.
- R6: A high-level request is offered while only a low-level handler is in service. No request is offered while a high-level handler is in service. A low-level request is not offered while a low-level handler is in service.
- R7: The vector equals 0x0003 + 8 × (source position from R2): 0x0003, 0x000B, 0x0013, 0x001B, 0x0023, 0x002B. `irq_vec` reads 0 whenever `irq_req` is low.
- R8: A timer pulse or an external edge sampled at clock edge k raises `irq_req` after edge k+1, provided the request is eligible. Until `irq_ack`, the request and vector stay steady while the source remains the winner. The request is withdrawn if the source stops being the winner.
- R9: On acknowledge, the flag of a timer, or of an external source in edge mode, is cleared. The serial flag and an external flag in level mode are not cleared.
- R10: The serial flag is the OR of `ser_rx_flag` and `ser_tx_flag`, sampled each clock.
- R11: In edge mode, a falling edge stays pending until it is serviced, even while blocked. In level mode the flag follows the inverted pin, so releasing the pin before acknowledge removes the request.
- R12: `irq_reti` clears the high-level in-service bit if it is set, and otherwise clears the low-level bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the enable register, 1 selects the priority register |
| cfg_wdata | input | 8 | Configuration write data |
| ext_irq_n | input | 2 | External request pins, active low (bit 0 external 0) |
| ext_edge_mode | input | 2 | 1 = edge mode, 0 = level mode, per external pin |
| tmr_ovf | input | 3 | Overflow pulses: timer 0, timer 1, extra timer |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| irq_ack | input | 1 | Core acknowledge, one cycle, only while `irq_req` is high |
| irq_reti | input | 1 | Return-from-handler strobe |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Handler address of the offered request |
| pend_flags | output | 6 | Pending flags in R2 bit positions |
| enable_q | output | 8 | Enable register |
| prio_q | output | 8 | Priority register |

## Verification
The assertions assume the core follows the handshake. `irq_ack` is a single-cycle pulse given only while `irq_req` is high. `irq_ack` and `irq_reti` never occur in the same cycle. `irq_reti` is pulsed only when a handler is in service. The stimulus keeps to these rules by building every acknowledge and return from one task each. Each task drives its strobe for exactly one cycle, and the return task is called only after a matching acknowledge. All inputs change on the falling clock edge, so every sampled input is stable at the rising edge.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int SRC_EXT0 = 0;
    localparam int SRC_TMR0 = 1;
    localparam int SRC_EXT1 = 2;
    localparam int SRC_TMR1 = 3;
    localparam int SRC_SER  = 4;
    localparam int SRC_TMR2 = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1
    } intc_state_e;

    typedef enum logic [1:0] {
        KIND_EXT   = 2'd0,
        KIND_TIMER = 2'd1,
        KIND_SER   = 2'd2
    } src_kind_e;

    function automatic src_kind_e kind_of(int idx);
        if (idx == SRC_EXT0 || idx == SRC_EXT1) return KIND_EXT;
        if (idx == SRC_SER) return KIND_SER;
        return KIND_TIMER;
    endfunction

endpackage

// File: rtl/intc_src_latch.sv
module intc_src_latch
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int NUM_EXT = 2,
    parameter int NUM_TMR = 3,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_pin_n,
    input  logic [NUM_EXT-1:0] ext_edge,
    input  logic [NUM_TMR-1:0] tmr_pulse,
    input  logic               ser_rx,
    input  logic               ser_tx,
    input  logic               clr_valid,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_SRC-1:0] flags
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam src_kind_e KIND = kind_of(i);
        logic flag_r;
        logic clr_hit;

        assign clr_hit  = clr_valid && (clr_idx == IDX_W'(i));
        assign flags[i] = flag_r;

        if (KIND == KIND_EXT) begin : g_ext
            localparam int E = i / 2;
            logic pin_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pin_q  <= 1'b1;
                    flag_r <= 1'b0;
                end else begin
                    pin_q <= ext_pin_n[E];
                    if (ext_edge[E]) begin
                        if (pin_q && !ext_pin_n[E]) flag_r <= 1'b1;
                        else if (clr_hit)           flag_r <= 1'b0;
                    end else begin
                        flag_r <= !ext_pin_n[E];
                    end
                end
            end

            assert_edge_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (ext_edge[E] && pin_q && !ext_pin_n[E]) |=> flag_r);

        end else if (KIND == KIND_SER) begin : g_ser
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flag_r <= 1'b0;
                else        flag_r <= ser_rx | ser_tx;
            end

            assert_ser_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (ser_rx || ser_tx) |=> flag_r);

        end else begin : g_tmr
            localparam int T = (i - 1) / 2;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            flag_r <= 1'b0;
                else if (tmr_pulse[T]) flag_r <= 1'b1;
                else if (clr_hit)      flag_r <= 1'b0;
            end

            assert_tmr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_hit && !tmr_pulse[T]) |=> !flag_r);
        end
    end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NUM_SRC = 6,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] flags,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               glob_en,
    input  logic [NUM_SRC-1:0] lvl_hi,
    input  logic               isv_hi,
    input  logic               isv_lo,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx,
    output logic               win_hi
);

    logic [NUM_SRC-1:0] armed;
    logic [NUM_SRC-1:0] elig_hi;
    logic [NUM_SRC-1:0] elig_lo;
    logic [NUM_SRC-1:0] elig;

    always_comb begin
        armed   = flags & src_en & {NUM_SRC{glob_en}};
        elig_hi = armed &  lvl_hi & {NUM_SRC{!isv_hi}};
        elig_lo = armed & ~lvl_hi & {NUM_SRC{!isv_hi && !isv_lo}};
        win_hi  = |elig_hi;
        elig    = win_hi ? elig_hi : elig_lo;
    end

    // Lowest index wins within the chosen level.
    always_comb begin
        win_valid = |elig;
        win_idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) win_idx = IDX_W'(i);
        end
    end

    assert_hi_blocks_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        isv_hi |-> !win_valid);

    assert_win_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> flags[win_idx]);

endmodule

// File: rtl/intc_fsm.sv
module intc_fsm
    import intc_pkg::*;
#(
    parameter int NUM_SRC    = 6,
    parameter int IDX_W      = $clog2(NUM_SRC),
    parameter int ADDR_W     = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_valid,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic              win_hi,
    input  logic              irq_ack,
    input  logic              irq_reti,
    output logic              irq_req,
    output logic [ADDR_W-1:0] irq_vec,
    output logic              isv_hi,
    output logic              isv_lo,
    output logic              clr_valid,
    output logic [IDX_W-1:0]  clr_idx
);

    intc_state_e      state_q, state_d;
    logic [IDX_W-1:0] cur_idx_q;
    logic             cur_hi_q;
    logic             service;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: take, service, withdraw
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (win_valid) state_d = ST_OFFER;
            end
            ST_OFFER: begin
                if (irq_ack)
                    state_d = ST_IDLE;
                else if (!win_valid || win_idx != cur_idx_q || win_hi != cur_hi_q)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_idx_q <= '0;
            cur_hi_q  <= 1'b0;
        end else if (state_q == ST_IDLE && win_valid) begin
            cur_idx_q <= win_idx;
            cur_hi_q  <= win_hi;
        end
    end

    // Outputs
    always_comb begin
        irq_req   = (state_q == ST_OFFER);
        service   = irq_req && irq_ack;
        irq_vec   = irq_req ? ADDR_W'(VEC_BASE + VEC_STRIDE * int'(cur_idx_q)) : '0;
        clr_valid = service;
        clr_idx   = cur_idx_q;
    end

    // In-service tracking per level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isv_hi <= 1'b0;
            isv_lo <= 1'b0;
        end else if (service) begin
            if (cur_hi_q) isv_hi <= 1'b1;
            else          isv_lo <= 1'b1;
        end else if (irq_reti) begin
            if (isv_hi) isv_hi <= 1'b0;
            else        isv_lo <= 1'b0;
        end
    end

    assert_vec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (!irq_req || $stable(irq_vec)));

    assert_ack_in_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> irq_req);

    assert_isv_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> (isv_hi || isv_lo));

    assert_reti_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack && irq_reti));

    assert_reti_hi_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_reti && isv_hi) |=> (!isv_hi && $stable(isv_lo)));

    assert_vec_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'd3));

endmodule

// File: rtl/intc_two_level.sv
module intc_two_level #(
    parameter int NUM_SRC    = 6,
    parameter int NUM_EXT    = 2,
    parameter int NUM_TMR    = 3,
    parameter int REG_W      = 8,
    parameter int ADDR_W     = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8,
    parameter int GLOB_BIT   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [REG_W-1:0]   cfg_wdata,
    input  logic [NUM_EXT-1:0] ext_irq_n,
    input  logic [NUM_EXT-1:0] ext_edge_mode,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic               ser_rx_flag,
    input  logic               ser_tx_flag,
    input  logic               irq_ack,
    input  logic               irq_reti,
    output logic               irq_req,
    output logic [ADDR_W-1:0]  irq_vec,
    output logic [NUM_SRC-1:0] pend_flags,
    output logic [REG_W-1:0]   enable_q,
    output logic [REG_W-1:0]   prio_q
);

    localparam int IDX_W = $clog2(NUM_SRC);
    localparam logic [REG_W-1:0] SRC_MASK = REG_W'((1 << NUM_SRC) - 1);
    localparam logic [REG_W-1:0] EN_MASK  = SRC_MASK | REG_W'(1 << GLOB_BIT);

    logic [REG_W-1:0] en_r, pri_r;
    logic             win_valid, win_hi;
    logic [IDX_W-1:0] win_idx;
    logic             isv_hi, isv_lo;
    logic             clr_valid;
    logic [IDX_W-1:0] clr_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_r  <= '0;
            pri_r <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) pri_r <= cfg_wdata & SRC_MASK;
            else         en_r  <= cfg_wdata & EN_MASK;
        end
    end

    assign enable_q = en_r;
    assign prio_q   = pri_r;

    intc_src_latch #(
        .NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .NUM_TMR(NUM_TMR), .IDX_W(IDX_W)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_pin_n(ext_irq_n),
        .ext_edge (ext_edge_mode),
        .tmr_pulse(tmr_ovf),
        .ser_rx   (ser_rx_flag),
        .ser_tx   (ser_tx_flag),
        .clr_valid(clr_valid),
        .clr_idx  (clr_idx),
        .flags    (pend_flags)
    );

    intc_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags    (pend_flags),
        .src_en   (en_r[NUM_SRC-1:0]),
        .glob_en  (en_r[GLOB_BIT]),
        .lvl_hi   (pri_r[NUM_SRC-1:0]),
        .isv_hi   (isv_hi),
        .isv_lo   (isv_lo),
        .win_valid(win_valid),
        .win_idx  (win_idx),
        .win_hi   (win_hi)
    );

    intc_fsm #(
        .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
        .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_valid(win_valid),
        .win_idx  (win_idx),
        .win_hi   (win_hi),
        .irq_ack  (irq_ack),
        .irq_reti (irq_reti),
        .irq_req  (irq_req),
        .irq_vec  (irq_vec),
        .isv_hi   (isv_hi),
        .isv_lo   (isv_lo),
        .clr_valid(clr_valid),
        .clr_idx  (clr_idx)
    );

    assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(en_r[GLOB_BIT]));

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prio_q[REG_W-1:NUM_SRC] == '0);

endmodule

// File: tb/test_intc_two_level.sv
module test_intc_two_level;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [1:0]  ext_n = 2'b11, ext_edge = 2'b11;
    logic [2:0]  tmr = 3'b000;
    logic        ser_rx = 1'b0, ser_tx = 1'b0;
    logic        irq_ack = 1'b0, irq_reti = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [5:0]  pend;
    logic [7:0]  en_o, pri_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_two_level i_intc_two_level (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ext_irq_n(ext_n), .ext_edge_mode(ext_edge),
        .tmr_ovf(tmr), .ser_rx_flag(ser_rx), .ser_tx_flag(ser_tx),
        .irq_ack(irq_ack), .irq_reti(irq_reti), .irq_req(irq_req),
        .irq_vec(irq_vec), .pend_flags(pend), .enable_q(en_o), .prio_q(pri_o)
    );

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit  m_flag[6];
    bit  m_pin[2];
    bit  m_offer, m_cur_hi, m_isv_hi, m_isv_lo;
    int  m_cur;
    int  m_en, m_pri;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_flag[i]) m_flag[i] = 0;
            m_pin[0] = 1; m_pin[1] = 1;
            m_offer = 0; m_cur = 0; m_cur_hi = 0;
            m_isv_hi = 0; m_isv_lo = 0; m_en = 0; m_pri = 0;
        end else begin
            bit wv, wh, hit;
            int wi;
            wv = 0; wh = 0; wi = 0;
            for (int lvl = 1; lvl >= 0 && !wv; lvl--) begin
                bit ok;
                ok = (lvl == 1) ? !m_isv_hi : (!m_isv_hi && !m_isv_lo);
                for (int s = 0; s < 6 && !wv; s++) begin
                    if (ok && m_flag[s] && m_en[s] && m_en[7] && (m_pri[s] == lvl[0])) begin
                        wv = 1; wi = s; wh = lvl[0];
                    end
                end
            end
            hit = m_offer && irq_ack;
            for (int e = 0; e < 2; e++) begin
                int s;
                s = 2 * e;
                if (ext_edge[e]) begin
                    if (m_pin[e] && !ext_n[e]) m_flag[s] = 1;
                    else if (hit && m_cur == s) m_flag[s] = 0;
                end else m_flag[s] = !ext_n[e];
                m_pin[e] = ext_n[e];
            end
            for (int t = 0; t < 3; t++) begin
                int s;
                s = 2 * t + 1;
                if (tmr[t]) m_flag[s] = 1;
                else if (hit && m_cur == s) m_flag[s] = 0;
            end
            m_flag[4] = ser_rx | ser_tx;
            if (hit) begin
                if (m_cur_hi) m_isv_hi = 1; else m_isv_lo = 1;
            end else if (irq_reti) begin
                if (m_isv_hi) m_isv_hi = 0; else m_isv_lo = 0;
            end
            if (!m_offer) begin
                if (wv) begin m_offer = 1; m_cur = wi; m_cur_hi = wh; end
            end else if (hit || !wv || wi != m_cur || wh != m_cur_hi) m_offer = 0;
            if (cfg_we) begin
                if (cfg_sel) m_pri = cfg_wdata & 8'h3F;
                else         m_en  = cfg_wdata & 8'hBF;
            end
        end
        #2;
        if (rst_n && !finished) begin
            int pm;
            pm = 0;
            foreach (m_flag[i]) pm |= int'(m_flag[i]) << i;
            chk("R8 model irq_req", int'(irq_req), int'(m_offer));
            chk("R7 model irq_vec", int'(irq_vec), m_offer ? 3 + 8 * m_cur : 0);
            chk("R9 model pend_flags", int'(pend), pm);
            chk("R2 model enable_q", int'(en_o), m_en);
            chk("R4 model prio_q", int'(pri_o), m_pri);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wcfg(bit sel, logic [7:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic pulse_tmr(int t);
        tmr[t] = 1'b1;
        @(negedge clk);
        tmr[t] = 1'b0;
    endtask

    task automatic wreq(string tag, int vec);
        for (int k = 0; k < 12; k++) begin
            if (irq_req) break;
            @(negedge clk);
        end
        chk({tag, " req"}, int'(irq_req), 1);
        chk({tag, " vec"}, int'(irq_vec), vec);
    endtask

    task automatic serve(string tag, int vec);
        wreq(tag, vec);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic ret();
        irq_reti = 1'b1;
        @(negedge clk);
        irq_reti = 1'b0;
    endtask

    task automatic quiet(string tag, int n);
        repeat (n) begin
            @(negedge clk);
            chk(tag, int'(irq_req), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got hung expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 enable_q", int'(en_o), 0);
        chk("R1 prio_q", int'(pri_o), 0);
        chk("R1 pend", int'(pend), 0);
        chk("R1 irq_req", int'(irq_req), 0);

        // R2 layout masks, R4 reserved bits
        wcfg(0, 8'hFF); cyc(1);
        chk("R2 bit6 reads 0", int'(en_o), 8'hBF);
        wcfg(1, 8'hFF); cyc(1);
        chk("R4 reserved read 0", int'(pri_o), 8'h3F);
        wcfg(0, 8'h00); wcfg(1, 8'h00);

        // R2/R3 gating and latching of a timer
        pulse_tmr(0);
        quiet("R2 no enable", 5);
        chk("R3 flag kept", int'(pend[1]), 1);
        wcfg(0, 8'h02);
        quiet("R3 global off", 5);
        wcfg(0, 8'h82);
        serve("R7 timer0", 16'h000B);
        chk("R9 timer flag cleared", int'(pend[1]), 0);
        ret();
        quiet("R12 idle after return", 3);

        // R5 fixed order at one level
        wcfg(0, 8'hBF);
        ext_n = 2'b00; tmr[1] = 1'b1;
        @(negedge clk);
        ext_n = 2'b11; tmr[1] = 1'b0;
        serve("R5 first ext0", 16'h0003); ret();
        serve("R5 second ext1", 16'h0013); ret();
        serve("R5 third timer1", 16'h001B); ret();

        // R4 high level wins
        wcfg(1, 8'h04);
        ext_n = 2'b00; tmr[0] = 1'b1;
        @(negedge clk);
        ext_n = 2'b11; tmr[0] = 1'b0;
        serve("R4 high ext1", 16'h0013); ret();
        serve("R4 then ext0", 16'h0003); ret();
        serve("R4 then timer0", 16'h000B); ret();

        // R6 nesting, R12 return order
        wcfg(1, 8'h08);
        pulse_tmr(0);
        serve("R6 low handler", 16'h000B);
        ext_n[0] = 1'b0; @(negedge clk); ext_n[0] = 1'b1;
        quiet("R6 same level blocked", 6);
        pulse_tmr(1);
        serve("R6 preempt", 16'h001B);
        ret();
        quiet("R12 low still in service", 4);
        chk("R11 edge kept while blocked", int'(pend[0]), 1);
        ret();
        serve("R12 low released", 16'h0003); ret();

        // R6 high blocks low
        pulse_tmr(1);
        serve("R6 high handler", 16'h001B);
        pulse_tmr(0);
        quiet("R6 low waits", 6);
        ret();
        serve("R6 low after high", 16'h000B); ret();

        // R10 serial OR, R9 no hardware clear
        wcfg(1, 8'h00); wcfg(0, 8'h90);
        ser_rx = 1'b1;
        serve("R10 rx", 16'h0023);
        chk("R9 serial kept", int'(pend[4]), 1);
        ret();
        wreq("R10 rx again", 16'h0023);
        ser_rx = 1'b0;
        cyc(3);
        chk("R8 withdraw", int'(irq_req), 0);
        chk("R10 flag low", int'(pend[4]), 0);
        ser_tx = 1'b1;
        serve("R10 tx", 16'h0023);
        ser_tx = 1'b0;
        ret();
        quiet("R10 both low", 3);

        // R11 level mode
        ext_edge = 2'b01;
        wcfg(0, 8'h84);
        ext_n[1] = 1'b0;
        wreq("R11 level", 16'h0013);
        ext_n[1] = 1'b1;
        cyc(3);
        chk("R11 release withdraws", int'(irq_req), 0);
        ext_n[1] = 1'b0;
        serve("R11 level again", 16'h0013);
        chk("R9 level not cleared", int'(pend[2]), 1);
        ext_n[1] = 1'b1;
        ret();
        cyc(2);
        chk("R11 level follows pin", int'(pend[2]), 0);
        ext_edge = 2'b11;

        // R11 edge latched while globally disabled
        wcfg(0, 8'h01);
        ext_n[0] = 1'b0; @(negedge clk); ext_n[0] = 1'b1;
        cyc(2);
        chk("R11 edge latched", int'(pend[0]), 1);
        quiet("R3 global off edge", 3);
        wcfg(0, 8'h81);
        serve("R11 edge served", 16'h0003);
        chk("R9 edge cleared", int'(pend[0]), 0);
        ret();

        // R8 latency, R7 extra timer vector
        wcfg(0, 8'hA0);
        tmr[2] = 1'b1;
        @(negedge clk);
        tmr[2] = 1'b0;
        chk("R8 one edge later", int'(irq_req), 0);
        @(negedge clk);
        chk("R8 two edges later", int'(irq_req), 1);
        serve("R7 extra timer", 16'h002B);
        ret();
        cyc(3);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule